// File: doc/BRIEF.md
# Video Stream Statistics Monitor

This block sits beside a camera-serial packet receiver and turns its event strobes into error and picture-geometry statistics. Each clock cycle it may see any mix of five strobes: a header that could not be repaired (the packet was thrown away), a header that was repaired, a long packet whose checksum failed, a frame-start short packet, and the end of a long packet together with that packet's pixel count. It keeps a saturating counter for each of the three error kinds. It also measures the number of long packets in each frame and the number of pixels in each long packet, and keeps a running maximum and minimum of both.

Software reaches the statistics and a few receiver control fields through an AXI4-Lite slave with 32-bit words. The control fields are the byte-synchronization enable, the sensor bus address and two lane delay values. A clear action and a delay-apply action fire only when their control bit goes from 0 to 1. Writing a 1 over a 1 does nothing. The delay values reach the receiver only through the apply action, which also gives a one-cycle load pulse.

Top module: `vstat_monitor`

## Requirements
- R1: Each cycle with `evt_hdr_drop` high adds one to the dropped-header counter, read at byte offset 0x18. The new value is visible from the next cycle.
- R2: Each cycle with `evt_hdr_fix` high adds one to the corrected-header counter, read at offset 0x1C.
- R3: Each cycle with `evt_crc_bad` high adds one to the checksum-failure counter, read at offset 0x20.
- R4: The three error counters stop at all ones (2^CNT_W-1) and never wrap.
- R5: The long packets between two successive frame starts make up the line count of one frame. That count updates the maximum (0x24) and the minimum (0x28) lines per frame. Packets before the first frame start after reset or clear are never committed. A packet end in the same cycle as a frame start belongs to the frame being closed.
- R6: Each packet end updates the maximum (0x2C) and the minimum (0x30) pixels per line with `evt_pkt_pixels`.
- R7: After reset or clear, the counters and maxima read 0 and the minima read all ones. After reset, all control fields, `sync_en`, the lane outputs and `dly_load` are 0.
- R8: Writing to bit 0 at offset 0x00 clears all statistics only when the stored bit goes from 0 to 1. The bit reads back at 0x00.
- R9: Bits [DLY_W-1:0] at 0x0C (lane 0) and 0x10 (lane 1) are stored and read back. They reach `lane0_dly`/`lane1_dly` only when bit 0 at 0x14 goes from 0 to 1. At that edge `dly_load` is high for exactly one cycle.
- R10: `sync_en` follows bit 0 at offset 0x04. `sensor_addr` follows bits [SADDR_W-1:0] at offset 0x08.
- R11: Every response is OKAY (00). Writes to read-only, unmapped or unaligned addresses change nothing. Reads of unmapped or unaligned addresses return 0.
- R12: The write address and write data channels are accepted independently, in either order. A write completes with one response. `s_bvalid` and `s_rvalid` stay high, and `s_rdata` stays unchanged, until the master is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_hdr_drop | input | 1 | Uncorrectable header, packet dropped |
| evt_hdr_fix | input | 1 | Header corrected |
| evt_crc_bad | input | 1 | Long packet checksum failure |
| evt_frame_start | input | 1 | Frame-start short packet seen |
| evt_pkt_end | input | 1 | Long packet ended |
| evt_pkt_pixels | input | PIX_W | Pixel count of the ending packet |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| sync_en | output | 1 | Byte-synchronization enable |
| sensor_addr | output | SADDR_W | Sensor bus slave address |
| lane0_dly | output | DLY_W | Applied lane 0 delay |
| lane1_dly | output | DLY_W | Applied lane 1 delay |
| dly_load | output | 1 | One-cycle pulse when new delays are applied |

## Verification
The properties assume a well-behaved AXI4-Lite master. Once it raises a valid, it holds the address or data steady until that channel is accepted. The monotonic-counter and ordering properties also assume that the pixel count is meaningful whenever the packet-end strobe is high. The bench keeps within these limits: its transfer tasks keep valid and payload steady until the ready seen at the falling edge lets them go, and it sets the pixel count in the same step as the strobe. Event strobes are idle during register traffic, so a clear never meets an event in the same cycle.

// File: rtl/vstat_pkg.sv
package vstat_pkg;
    // word index of each register (byte offset / 4)
    localparam int REG_CLR      = 0;
    localparam int REG_PHY      = 1;
    localparam int REG_SADDR    = 2;
    localparam int REG_DLY0     = 3;
    localparam int REG_DLY1     = 4;
    localparam int REG_ACT      = 5;
    localparam int REG_ERR_DROP = 6;
    localparam int REG_ERR_FIX  = 7;
    localparam int REG_ERR_CRC  = 8;
    localparam int REG_LN_MAX   = 9;
    localparam int REG_LN_MIN   = 10;
    localparam int REG_PX_MAX   = 11;
    localparam int REG_PX_MIN   = 12;

    localparam int NUM_ERR      = 3;
    localparam int ERR_DROP     = 0;
    localparam int ERR_FIX      = 1;
    localparam int ERR_CRC      = 2;

    localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/vstat_err_cnt.sv
module vstat_err_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hit,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (hit && (cnt_q != '1)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/vstat_geom.sv
module vstat_geom #(
    parameter int LINE_W = 16,
    parameter int PIX_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              frame_start,
    input  logic              pkt_end,
    input  logic [PIX_W-1:0]  pkt_pixels,
    output logic [LINE_W-1:0] line_max,
    output logic [LINE_W-1:0] line_min,
    output logic [PIX_W-1:0]  pix_max,
    output logic [PIX_W-1:0]  pix_min
);
    typedef struct packed {
        logic              seen_fs;
        logic [LINE_W-1:0] line_cnt;
        logic [LINE_W-1:0] line_max;
        logic [LINE_W-1:0] line_min;
        logic [PIX_W-1:0]  pix_max;
        logic [PIX_W-1:0]  pix_min;
    } geom_t;

    localparam geom_t GEOM_INIT = '{
        seen_fs:  1'b0,
        line_cnt: '0,
        line_max: '0,
        line_min: '1,
        pix_max:  '0,
        pix_min:  '1
    };

    geom_t             st_d, st_q;
    logic [LINE_W-1:0] lines_now;

    always_comb begin
        st_d      = st_q;
        lines_now = st_q.line_cnt;
        if (pkt_end && (st_q.line_cnt != '1)) begin
            lines_now = st_q.line_cnt + 1'b1;
        end
        if (clr) begin
            st_d = GEOM_INIT;
        end else begin
            if (pkt_end) begin
                if (pkt_pixels > st_q.pix_max) st_d.pix_max = pkt_pixels;
                if (pkt_pixels < st_q.pix_min) st_d.pix_min = pkt_pixels;
            end
            if (frame_start) begin
                if (st_q.seen_fs) begin
                    if (lines_now > st_q.line_max) st_d.line_max = lines_now;
                    if (lines_now < st_q.line_min) st_d.line_min = lines_now;
                end
                st_d.line_cnt = '0;
                st_d.seen_fs  = 1'b1;
            end else if (pkt_end) begin
                st_d.line_cnt = lines_now;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= GEOM_INIT;
        else        st_q <= st_d;
    end

    assign line_max = st_q.line_max;
    assign line_min = st_q.line_min;
    assign pix_max  = st_q.pix_max;
    assign pix_min  = st_q.pix_min;
endmodule

// File: rtl/vstat_axil_regs.sv
module vstat_axil_regs
    import vstat_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int CNT_W   = 32,
    parameter int LINE_W  = 16,
    parameter int PIX_W   = 16,
    parameter int DLY_W   = 5,
    parameter int SADDR_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  s_awaddr,
    input  logic               s_awvalid,
    output logic               s_awready,
    input  logic [31:0]        s_wdata,
    input  logic               s_wvalid,
    output logic               s_wready,
    output logic [1:0]         s_bresp,
    output logic               s_bvalid,
    input  logic               s_bready,
    input  logic [ADDR_W-1:0]  s_araddr,
    input  logic               s_arvalid,
    output logic               s_arready,
    output logic [31:0]        s_rdata,
    output logic [1:0]         s_rresp,
    output logic               s_rvalid,
    input  logic               s_rready,
    input  logic [CNT_W-1:0]   err_drop,
    input  logic [CNT_W-1:0]   err_fix,
    input  logic [CNT_W-1:0]   err_crc,
    input  logic [LINE_W-1:0]  line_max,
    input  logic [LINE_W-1:0]  line_min,
    input  logic [PIX_W-1:0]   pix_max,
    input  logic [PIX_W-1:0]   pix_min,
    output logic               stat_clr,
    output logic               sync_en,
    output logic [SADDR_W-1:0] sensor_addr,
    output logic [DLY_W-1:0]   lane0_dly,
    output logic [DLY_W-1:0]   lane1_dly,
    output logic               dly_load
);
    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic               aw_have;
        logic               aw_ok;
        logic [IDX_W-1:0]   aw_idx;
        logic               w_have;
        logic [31:0]        w_data;
        logic               bvalid;
        logic               rvalid;
        logic [31:0]        rdata;
        logic               clr_bit;
        logic               phy_bit;
        logic [SADDR_W-1:0] saddr;
        logic [DLY_W-1:0]   dly0_reg;
        logic [DLY_W-1:0]   dly1_reg;
        logic               act_bit;
        logic [DLY_W-1:0]   dly0_out;
        logic [DLY_W-1:0]   dly1_out;
        logic               load;
    } regs_t;

    regs_t       st_d, st_q;
    logic        wr_fire;
    logic        clr_pulse;
    logic [31:0] rd_word;
    logic        unused_wbits;

    assign s_awready = !st_q.aw_have && !st_q.bvalid;
    assign s_wready  = !st_q.w_have && !st_q.bvalid;
    assign s_arready = !st_q.rvalid;
    assign wr_fire   = st_q.aw_have && st_q.w_have && !st_q.bvalid;

    // read multiplexer, looked up when the read address is accepted
    always_comb begin
        rd_word = '0;
        if (s_araddr[1:0] == 2'b00) begin
            case (int'(s_araddr[ADDR_W-1:2]))
                REG_CLR:      rd_word = 32'(st_q.clr_bit);
                REG_PHY:      rd_word = 32'(st_q.phy_bit);
                REG_SADDR:    rd_word = 32'(st_q.saddr);
                REG_DLY0:     rd_word = 32'(st_q.dly0_reg);
                REG_DLY1:     rd_word = 32'(st_q.dly1_reg);
                REG_ACT:      rd_word = 32'(st_q.act_bit);
                REG_ERR_DROP: rd_word = 32'(err_drop);
                REG_ERR_FIX:  rd_word = 32'(err_fix);
                REG_ERR_CRC:  rd_word = 32'(err_crc);
                REG_LN_MAX:   rd_word = 32'(line_max);
                REG_LN_MIN:   rd_word = 32'(line_min);
                REG_PX_MAX:   rd_word = 32'(pix_max);
                REG_PX_MIN:   rd_word = 32'(pix_min);
                default:      rd_word = '0;
            endcase
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;
        clr_pulse = 1'b0;

        if (s_awvalid && s_awready) begin
            st_d.aw_have = 1'b1;
            st_d.aw_ok   = (s_awaddr[1:0] == 2'b00);
            st_d.aw_idx  = s_awaddr[ADDR_W-1:2];
        end
        if (s_wvalid && s_wready) begin
            st_d.w_have = 1'b1;
            st_d.w_data = s_wdata;
        end

        if (wr_fire) begin
            st_d.aw_have = 1'b0;
            st_d.w_have  = 1'b0;
            st_d.bvalid  = 1'b1;
            if (st_q.aw_ok) begin
                case (int'(st_q.aw_idx))
                    REG_CLR: begin
                        st_d.clr_bit = st_q.w_data[0];
                        clr_pulse    = st_q.w_data[0] && !st_q.clr_bit;
                    end
                    REG_PHY:   st_d.phy_bit  = st_q.w_data[0];
                    REG_SADDR: st_d.saddr    = st_q.w_data[SADDR_W-1:0];
                    REG_DLY0:  st_d.dly0_reg = st_q.w_data[DLY_W-1:0];
                    REG_DLY1:  st_d.dly1_reg = st_q.w_data[DLY_W-1:0];
                    REG_ACT: begin
                        st_d.act_bit = st_q.w_data[0];
                        if (st_q.w_data[0] && !st_q.act_bit) begin
                            st_d.load     = 1'b1;
                            st_d.dly0_out = st_q.dly0_reg;
                            st_d.dly1_out = st_q.dly1_reg;
                        end
                    end
                    default: ;
                endcase
            end
        end

        if (st_q.bvalid && s_bready) begin
            st_d.bvalid = 1'b0;
        end

        if (s_arvalid && s_arready) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = rd_word;
        end else if (st_q.rvalid && s_rready) begin
            st_d.rvalid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign unused_wbits = ^st_q.w_data;

    assign s_bresp     = RESP_OKAY;
    assign s_bvalid    = st_q.bvalid;
    assign s_rresp     = RESP_OKAY;
    assign s_rvalid    = st_q.rvalid;
    assign s_rdata     = st_q.rdata;
    assign stat_clr    = clr_pulse;
    assign sync_en     = st_q.phy_bit;
    assign sensor_addr = st_q.saddr;
    assign lane0_dly   = st_q.dly0_out;
    assign lane1_dly   = st_q.dly1_out;
    assign dly_load    = st_q.load;
endmodule

// File: rtl/vstat_monitor.sv
module vstat_monitor
    import vstat_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int CNT_W   = 32,
    parameter int LINE_W  = 16,
    parameter int PIX_W   = 16,
    parameter int DLY_W   = 5,
    parameter int SADDR_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_hdr_drop,
    input  logic               evt_hdr_fix,
    input  logic               evt_crc_bad,
    input  logic               evt_frame_start,
    input  logic               evt_pkt_end,
    input  logic [PIX_W-1:0]   evt_pkt_pixels,
    input  logic [ADDR_W-1:0]  s_awaddr,
    input  logic               s_awvalid,
    output logic               s_awready,
    input  logic [31:0]        s_wdata,
    input  logic               s_wvalid,
    output logic               s_wready,
    output logic [1:0]         s_bresp,
    output logic               s_bvalid,
    input  logic               s_bready,
    input  logic [ADDR_W-1:0]  s_araddr,
    input  logic               s_arvalid,
    output logic               s_arready,
    output logic [31:0]        s_rdata,
    output logic [1:0]         s_rresp,
    output logic               s_rvalid,
    input  logic               s_rready,
    output logic               sync_en,
    output logic [SADDR_W-1:0] sensor_addr,
    output logic [DLY_W-1:0]   lane0_dly,
    output logic [DLY_W-1:0]   lane1_dly,
    output logic               dly_load
);
    logic                          stat_clr;
    logic [NUM_ERR-1:0]            err_hit;
    logic [NUM_ERR-1:0][CNT_W-1:0] err_cnt;
    logic [LINE_W-1:0]             line_max, line_min;
    logic [PIX_W-1:0]              pix_max, pix_min;

    always_comb begin
        err_hit           = '0;
        err_hit[ERR_DROP] = evt_hdr_drop;
        err_hit[ERR_FIX]  = evt_hdr_fix;
        err_hit[ERR_CRC]  = evt_crc_bad;
    end

    for (genvar k = 0; k < NUM_ERR; k++) begin : g_err
        vstat_err_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (stat_clr),
            .hit   (err_hit[k]),
            .cnt   (err_cnt[k])
        );
    end

    vstat_geom #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_geom (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (stat_clr),
        .frame_start (evt_frame_start),
        .pkt_end     (evt_pkt_end),
        .pkt_pixels  (evt_pkt_pixels),
        .line_max    (line_max),
        .line_min    (line_min),
        .pix_max     (pix_max),
        .pix_min     (pix_min)
    );

    vstat_axil_regs #(
        .ADDR_W (ADDR_W), .CNT_W (CNT_W), .LINE_W (LINE_W),
        .PIX_W  (PIX_W),  .DLY_W (DLY_W), .SADDR_W(SADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .s_awaddr    (s_awaddr),
        .s_awvalid   (s_awvalid),
        .s_awready   (s_awready),
        .s_wdata     (s_wdata),
        .s_wvalid    (s_wvalid),
        .s_wready    (s_wready),
        .s_bresp     (s_bresp),
        .s_bvalid    (s_bvalid),
        .s_bready    (s_bready),
        .s_araddr    (s_araddr),
        .s_arvalid   (s_arvalid),
        .s_arready   (s_arready),
        .s_rdata     (s_rdata),
        .s_rresp     (s_rresp),
        .s_rvalid    (s_rvalid),
        .s_rready    (s_rready),
        .err_drop    (err_cnt[ERR_DROP]),
        .err_fix     (err_cnt[ERR_FIX]),
        .err_crc     (err_cnt[ERR_CRC]),
        .line_max    (line_max),
        .line_min    (line_min),
        .pix_max     (pix_max),
        .pix_min     (pix_min),
        .stat_clr    (stat_clr),
        .sync_en     (sync_en),
        .sensor_addr (sensor_addr),
        .lane0_dly   (lane0_dly),
        .lane1_dly   (lane1_dly),
        .dly_load    (dly_load)
    );
endmodule

// File: rtl/vstat_monitor_chk.sv
module vstat_monitor_chk #(
    parameter int CNT_W = 32,
    parameter int PIX_W = 16,
    parameter int DLY_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_hdr_drop,
    input logic             evt_pkt_end,
    input logic             stat_clr,
    input logic [CNT_W-1:0] drop_cnt,
    input logic [PIX_W-1:0] pix_max,
    input logic [PIX_W-1:0] pix_min,
    input logic             s_bvalid,
    input logic             s_bready,
    input logic             s_rvalid,
    input logic             s_rready,
    input logic [31:0]      s_rdata,
    input logic             dly_load,
    input logic [DLY_W-1:0] lane0_dly,
    input logic [DLY_W-1:0] lane1_dly
);
    // R12
    bresp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> s_bvalid);

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));

    // R9
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dly_load |=> !dly_load);

    // R9
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dly_load |-> ($stable(lane0_dly) && $stable(lane1_dly)));

    // R4
    drop_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clr |=> (drop_cnt >= $past(drop_cnt)));

    // R1
    drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_clr && !evt_hdr_drop) |=> $stable(drop_cnt));

    // R6
    pix_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pkt_end && !stat_clr) |=> (pix_max >= pix_min));
endmodule

bind vstat_monitor vstat_monitor_chk #(
    .CNT_W (CNT_W), .PIX_W (PIX_W), .DLY_W (DLY_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_hdr_drop (evt_hdr_drop),
    .evt_pkt_end  (evt_pkt_end),
    .stat_clr     (stat_clr),
    .drop_cnt     (err_cnt[0]),
    .pix_max      (pix_max),
    .pix_min      (pix_min),
    .s_bvalid     (s_bvalid),
    .s_bready     (s_bready),
    .s_rvalid     (s_rvalid),
    .s_rready     (s_rready),
    .s_rdata      (s_rdata),
    .dly_load     (dly_load),
    .lane0_dly    (lane0_dly),
    .lane1_dly    (lane1_dly)
);

// File: tb/vstat_monitor_bench.sv
module vstat_monitor_bench;
    localparam int ADDR_W  = 6;
    localparam int CNT_W   = 6;
    localparam int LINE_W  = 16;
    localparam int PIX_W   = 16;
    localparam int DLY_W   = 5;
    localparam int SADDR_W = 7;
    localparam int CNT_SAT = (1 << CNT_W) - 1;
    localparam int LN_ONES = (1 << LINE_W) - 1;
    localparam int PX_ONES = (1 << PIX_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               evt_hdr_drop = 0, evt_hdr_fix = 0, evt_crc_bad = 0;
    logic               evt_frame_start = 0, evt_pkt_end = 0;
    logic [PIX_W-1:0]   evt_pkt_pixels = '0;
    logic [ADDR_W-1:0]  s_awaddr = '0, s_araddr = '0;
    logic               s_awvalid = 0, s_wvalid = 0, s_bready = 0;
    logic               s_arvalid = 0, s_rready = 0;
    logic [31:0]        s_wdata = '0;
    logic               s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0]         s_bresp, s_rresp;
    logic [31:0]        s_rdata;
    logic               sync_en, dly_load;
    logic [SADDR_W-1:0] sensor_addr;
    logic [DLY_W-1:0]   lane0_dly, lane1_dly;

    int n_checks = 0;
    int n_fail   = 0;
    logic last_load;
    logic [1:0] last_bresp;

    // bench model of the statistics
    int m_err [3];
    bit m_seen;
    int m_lines, m_lmax, m_lmin, m_pmax, m_pmin;

    always #2 clk = ~clk;

    vstat_monitor #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_W(LINE_W),
        .PIX_W(PIX_W), .DLY_W(DLY_W), .SADDR_W(SADDR_W)
    ) u_vstat_monitor (.*);

    task automatic check(input string tag, input longint got, input longint exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    function automatic void model_reset();
        for (int k = 0; k < 3; k++) m_err[k] = 0;
        m_seen = 0; m_lines = 0;
        m_lmax = 0; m_lmin = LN_ONES;
        m_pmax = 0; m_pmin = PX_ONES;
    endfunction

    function automatic int sat_inc(input int v, input int lim);
        return (v < lim) ? v + 1 : v;
    endfunction

    function automatic void model_step(input bit d, input bit f, input bit c,
                                       input bit fs, input bit pe, input int pix);
        int now;
        if (d) m_err[0] = sat_inc(m_err[0], CNT_SAT);
        if (f) m_err[1] = sat_inc(m_err[1], CNT_SAT);
        if (c) m_err[2] = sat_inc(m_err[2], CNT_SAT);
        now = pe ? sat_inc(m_lines, LN_ONES) : m_lines;
        if (pe) begin
            if (pix > m_pmax) m_pmax = pix;
            if (pix < m_pmin) m_pmin = pix;
        end
        if (fs) begin
            if (m_seen) begin
                if (now > m_lmax) m_lmax = now;
                if (now < m_lmin) m_lmin = now;
            end
            m_lines = 0; m_seen = 1;
        end else begin
            m_lines = now;
        end
    endfunction

    // one cycle of events, driven at the falling edge
    task automatic ev(input bit d, input bit f, input bit c,
                      input bit fs, input bit pe, input int pix);
        evt_hdr_drop = d; evt_hdr_fix = f; evt_crc_bad = c;
        evt_frame_start = fs; evt_pkt_end = pe; evt_pkt_pixels = PIX_W'(pix);
        model_step(d, f, c, fs, pe, pix);
        @(negedge clk);
        evt_hdr_drop = 0; evt_hdr_fix = 0; evt_crc_bad = 0;
        evt_frame_start = 0; evt_pkt_end = 0;
    endtask

    task automatic axi_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input int mode);
        bit aw_done = 0, w_done = 0, aw_take, w_take;
        s_awaddr = a; s_wdata = d;
        while (!(aw_done && w_done)) begin
            s_awvalid = !aw_done && (mode != 2 || w_done);
            s_wvalid  = !w_done && (mode != 1 || aw_done);
            aw_take = s_awvalid && s_awready;
            w_take  = s_wvalid && s_wready;
            @(negedge clk);
            if (aw_take) aw_done = 1;
            if (w_take)  w_done = 1;
        end
        s_awvalid = 0; s_wvalid = 0;
        while (!s_bvalid) @(negedge clk);
        last_load = dly_load; last_bresp = s_bresp;
        if (mode == 2) @(negedge clk);
        s_bready = 1;
        @(negedge clk);
        s_bready = 0;
    endtask

    task automatic axi_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        s_araddr = a; s_arvalid = 1;
        while (!s_arready) @(negedge clk);
        @(negedge clk);
        s_arvalid = 0;
        while (!s_rvalid) @(negedge clk);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        d = s_rdata;
        check("R11 rresp", s_rresp, 0);
        s_rready = 1;
        @(negedge clk);
        s_rready = 0;
    endtask

    task automatic read_check(input logic [ADDR_W-1:0] a, input string tag, input int exp);
        logic [31:0] v;
        axi_read(a, v);
        check(tag, v, exp);
    endtask

    task automatic check_stats(input string tag);
        read_check(6'h18, {tag, " R1 drop"}, m_err[0]);
        read_check(6'h1C, {tag, " R2 fix"}, m_err[1]);
        read_check(6'h20, {tag, " R3 crc"}, m_err[2]);
        read_check(6'h24, {tag, " R5 lmax"}, m_lmax);
        read_check(6'h28, {tag, " R5 lmin"}, m_lmin);
        read_check(6'h2C, {tag, " R6 pmax"}, m_pmax);
        read_check(6'h30, {tag, " R6 pmin"}, m_pmin);
    endtask

    task automatic random_events(input int n);
        for (int i = 0; i < n; i++) begin
            bit fs, pe;
            fs = ($urandom_range(0, 39) == 0);
            pe = !fs && ($urandom_range(0, 2) == 0);
            ev($urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0,
               $urandom_range(0, 15) == 0, fs, pe, $urandom_range(1, 3000));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R12 watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R7 reset state
        check("R7 sync_en", sync_en, 0);
        check("R7 lane0", lane0_dly, 0);
        check("R7 dly_load", dly_load, 0);
        check_stats("R7 reset");

        // R5 R6 directed frames, partial first frame ignored
        ev(0, 0, 0, 0, 1, 40);
        ev(0, 0, 0, 0, 1, 41);
        ev(0, 0, 0, 1, 0, 0);
        ev(0, 0, 0, 0, 1, 10);
        ev(0, 0, 0, 0, 1, 20);
        ev(0, 0, 0, 0, 1, 5);
        ev(0, 0, 0, 1, 0, 0);
        for (int i = 0; i < 5; i++) ev(0, 0, 0, 0, 1, 100);
        ev(0, 0, 0, 1, 1, 7);   // packet end shares the closing cycle
        check_stats("directed");
        read_check(6'h24, "R5 lmax directed", 6);
        read_check(6'h28, "R5 lmin directed", 3);
        read_check(6'h30, "R6 pmin directed", 5);

        // R8 clear on rising edge
        axi_write(6'h00, 1, 0); model_reset();
        check_stats("R8 clear");
        random_events(300);
        check_stats("rand A");
        axi_write(6'h00, 1, 1);   // 1 over 1: no clear
        check_stats("R8 no clear");
        random_events(300);
        check_stats("rand B");
        axi_write(6'h00, 0, 2);
        read_check(6'h00, "R8 readback", 0);
        axi_write(6'h00, 1, 0); model_reset();
        random_events(400);
        check_stats("rand C");

        // R4 saturation
        for (int i = 0; i < 80; i++) ev(1, i < 70, 0, 0, 0, 0);
        check_stats("R4 sat");

        // R9 delay apply
        axi_write(6'h0C, 32'h13, 0);
        axi_write(6'h10, 32'hE7, 1);
        check("R9 lane0 held", lane0_dly, 0);
        check("R9 lane1 held", lane1_dly, 0);
        read_check(6'h10, "R9 lane1 readback", 7);
        axi_write(6'h14, 1, 2);
        check("R9 load pulse", last_load, 1);
        check("R9 lane0 applied", lane0_dly, 19);
        check("R9 lane1 applied", lane1_dly, 7);
        check("R9 load ended", dly_load, 0);
        axi_write(6'h0C, 32'h02, 0);
        axi_write(6'h14, 1, 0);
        check("R9 no load on 1 over 1", last_load, 0);
        check("R9 lane0 kept", lane0_dly, 19);
        axi_write(6'h14, 0, 1);
        axi_write(6'h14, 1, 0);
        check("R9 reload lane0", lane0_dly, 2);

        // R10 control fields
        axi_write(6'h04, 1, 0);
        check("R10 sync_en on", sync_en, 1);
        axi_write(6'h08, 32'h3C5, 2);
        check("R10 sensor_addr", sensor_addr, 7'h45);
        read_check(6'h08, "R10 saddr readback", 32'h45);
        axi_write(6'h04, 0, 1);
        check("R10 sync_en off", sync_en, 0);

        // R11 ignored writes and empty reads
        axi_write(6'h18, 32'hFF, 0);
        check("R11 bresp", last_bresp, 0);
        axi_write(6'h05, 1, 0);
        check("R11 unaligned write", sync_en, 0);
        axi_write(6'h38, 1, 0);
        check_stats("R11 after ro writes");
        read_check(6'h34, "R11 unmapped", 0);
        read_check(6'h3C, "R11 unmapped top", 0);
        read_check(6'h19, "R11 unaligned read", 0);
        read_check(6'h0C, "R12 readback", 2);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule